// File: doc/BRIEF.md
# Dual-Mode Gain Code Latch

This block turns a two-bit gain-select bus and a load strobe, both arriving with no relation to the system clock, into a registered gain setting for a programmable-gain analog front end. The setting is given two ways: as a 2-bit exponent and as the decoded gain value (1, 2, 4 or 8, one-hot). A one-cycle pulse marks every change of the setting.

A mode input picks between two behaviours. In follow mode the setting tracks the select bus continuously. In strobe mode the select bus is read only when the strobe falls, so the bus can be shared with other devices between strobes. In strobe mode the setting leaves reset at gain 1. The strobe and the bus first pass through synchronisers.

While strobe mode is active, on-chip monitors measure four things in clock cycles after the synchronisers: how long the select value was stable before the falling strobe, whether it stays stable just after the fall, and how long the strobe spends high and low. Each breach sets its own sticky flag until software clears it.

Top module: `gain_latch_ctrl`

## Requirements
- R1: The gain code maps to the gain value as 00→1, 01→2, 10→4, 11→8 (`gain_val` = 1 shifted left by `gain_exp`, so exactly one bit of `gain_val` is set).
- R2: While `rst` is high and after its release, `gain_exp` is 00, `gain_val` is 1, `gain_chg` and all four error flags are 0. In strobe mode the code stays 00 until the first falling strobe, whatever the select bus carries.
- R3: With `latch_mode` = 0 the code follows `gain_sel`. A change driven before rising edge k shows on `gain_exp` after edge k+2 and not before.
- R4: With `latch_mode` = 1, a falling `load_strobe` loads the value of `gain_sel` that was present at the edge where the strobe was first seen low. The result shows after the same three edges as in R3.
- R5: With `latch_mode` = 1, a strobe that stays low, stays high or rises leaves the code unchanged, and any `gain_sel` change then has no effect.
- R6: A change of `latch_mode` acts at the next rising edge. Entering strobe mode keeps the current code until the next falling strobe.
- R7: `gain_chg` is high for exactly one cycle, the cycle in which `gain_exp` first shows a new value.
- R8: If `gain_sel` changed fewer than `SETUP_CYC` (default 2) edges before the falling strobe, `setup_err` is set. The code is still loaded.
- R9: If `gain_sel` changes within the first `HOLD_CYC`−1 edges after the falling strobe, `hold_err` is set. The loaded code is kept. A change `HOLD_CYC` edges after the fall is legal.
- R10: If the strobe was seen high for fewer than `HIGH_CYC` (default 3) edges before a fall, `high_err` is set. Exactly `HIGH_CYC` edges is legal.
- R11: If the strobe was seen low for fewer than `LOW_CYC` (default 3) edges before a rise, `low_err` is set. The low period that starts at reset counts as long enough.
- R12: Error flags are sticky until `viol_clr`. A breach in the same cycle as `viol_clr` wins. Strobe edges in follow mode raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_strobe | input | 1 | Asynchronous load strobe, active on its falling edge |
| gain_sel | input | CODE_W | Asynchronous gain-select bus |
| latch_mode | input | 1 | 0 = follow mode, 1 = strobe mode (clock-synchronous) |
| viol_clr | input | 1 | Clears the sticky error flags |
| gain_exp | output | CODE_W | Registered gain exponent |
| gain_val | output | 2**CODE_W | Registered one-hot gain value |
| gain_chg | output | 1 | One-cycle pulse on a new gain code |
| setup_err | output | 1 | Sticky select-to-strobe setup breach |
| hold_err | output | 1 | Sticky strobe-to-select hold breach |
| high_err | output | 1 | Sticky minimum strobe-high breach |
| low_err | output | 1 | Sticky minimum strobe-low breach |

## Verification
On every cycle the assertions check that the value is one-hot and matches the code, and that follow mode copies the synchronised bus. They also check that strobe mode changes the code only at a detected fall, that the change pulse matches a code change, and that every flag stays set until cleared. Only the bench scenarios show the latency from pins to outputs and the exact cycle counts at which setup, hold, high and low breaches start to be flagged. The same goes for the legal boundary cases, set winning over clear, and the silence of the monitors in follow mode.

// File: rtl/glc_pkg.sv
package glc_pkg;

  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_STROBE = 1'b1
  } glc_mode_e;

  // one sticky bit per timing monitor
  typedef struct packed {
    logic setup;
    logic hold;
    logic high;
    logic low;
  } glc_viol_t;

  localparam int VIOL_W = $bits(glc_viol_t);

endpackage

// File: rtl/glc_sync.sv
module glc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/glc_edge.sv
module glc_edge #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_s,
  input  logic [CODE_W-1:0] sel_s,
  input  logic              en,
  output logic              fall,
  output logic              rise,
  output logic              sel_chg
);

  logic              strobe_p;
  logic [CODE_W-1:0] sel_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_p <= 1'b0;
      sel_p    <= '0;
    end else begin
      strobe_p <= strobe_s;
      sel_p    <= sel_s;
    end
  end

  assign fall    = en &  strobe_p & ~strobe_s;
  assign rise    = en & ~strobe_p &  strobe_s;
  assign sel_chg = (sel_s != sel_p);

endmodule

// File: rtl/glc_timing_mon.sv
module glc_timing_mon
  import glc_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int HIGH_CYC  = 3,
  parameter int LOW_CYC   = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      strobe_s,
  input  logic      fall,
  input  logic      rise,
  input  logic      sel_chg,
  input  logic      viol_clr,
  output glc_viol_t viol
);

  localparam int MAX_AB = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_CD = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1) + 1;

  localparam logic [CW-1:0] SU_LIM   = CW'(SETUP_CYC);
  localparam logic [CW-1:0] HI_LIM   = CW'(HIGH_CYC);
  localparam logic [CW-1:0] LO_LIM   = CW'(LOW_CYC);
  localparam logic [CW-1:0] HD_START = (HOLD_CYC > 0) ? CW'(HOLD_CYC - 1) : '0;

  logic [CW-1:0] su_cnt, su_age;
  logic [CW-1:0] hd_win;
  logic [CW-1:0] hi_cnt, lo_cnt;
  glc_viol_t     bad, viol_q;

  // age of the current synchronised select value
  always_ff @(posedge clk) begin
    if (rst)                 su_cnt <= SU_LIM;
    else if (sel_chg)        su_cnt <= CW'(1);
    else if (su_cnt < SU_LIM) su_cnt <= su_cnt + CW'(1);
  end

  assign su_age = sel_chg ? '0 : su_cnt;

  // window after a fall in which the select must not move
  always_ff @(posedge clk) begin
    if (rst)              hd_win <= '0;
    else if (fall)        hd_win <= HD_START;
    else if (hd_win != 0) hd_win <= hd_win - CW'(1);
  end

  // run lengths of the synchronised strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= LO_LIM;
    end else begin
      if (!strobe_s)            hi_cnt <= '0;
      else if (hi_cnt < HI_LIM) hi_cnt <= hi_cnt + CW'(1);
      if (strobe_s)             lo_cnt <= '0;
      else if (lo_cnt < LO_LIM) lo_cnt <= lo_cnt + CW'(1);
    end
  end

  always_comb begin
    bad       = '0;
    bad.setup = fall && (su_age < SU_LIM);
    bad.hold  = (hd_win != 0) && sel_chg;
    bad.high  = fall && (hi_cnt < HI_LIM);
    bad.low   = rise && (lo_cnt < LO_LIM);
  end

  // sticky flags: a new breach has priority over the clear
  always_ff @(posedge clk) begin
    if (rst) viol_q <= '0;
    else     viol_q <= (viol_clr ? glc_viol_t'('0) : viol_q) | bad;
  end

  assign viol = viol_q;

endmodule

// File: rtl/glc_code_reg.sv
module glc_code_reg
  import glc_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int GAIN_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  glc_mode_e         mode,
  input  logic [CODE_W-1:0] sel_s,
  input  logic              fall,
  output logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain,
  output logic              chg
);

  logic [CODE_W-1:0] code_nx;

  always_comb begin
    code_nx = code;
    if (mode == MODE_FOLLOW || fall) code_nx = sel_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      gain <= GAIN_W'(1);
      chg  <= 1'b0;
    end else begin
      code <= code_nx;
      gain <= GAIN_W'(1) << code_nx;
      chg  <= (code_nx != code);
    end
  end

endmodule

// File: rtl/gain_latch_ctrl.sv
module gain_latch_ctrl
  import glc_pkg::*;
#(
  parameter int CODE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 2,
  parameter int HIGH_CYC    = 3,
  parameter int LOW_CYC     = 3,
  localparam int GAIN_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_strobe,
  input  logic [CODE_W-1:0] gain_sel,
  input  logic              latch_mode,
  input  logic              viol_clr,
  output logic [CODE_W-1:0] gain_exp,
  output logic [GAIN_W-1:0] gain_val,
  output logic              gain_chg,
  output logic              setup_err,
  output logic              hold_err,
  output logic              high_err,
  output logic              low_err
);

  localparam int BUS_W = CODE_W + 1;

  logic [BUS_W-1:0]  raw_bus, sync_bus;
  logic              strobe_s;
  logic [CODE_W-1:0] sel_s;
  logic              fall, rise, sel_chg;
  glc_mode_e         mode;
  glc_viol_t         viol;

  assign raw_bus = {load_strobe, gain_sel};
  assign mode    = latch_mode ? MODE_STROBE : MODE_FOLLOW;

  glc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  assign strobe_s = sync_bus[BUS_W-1];
  assign sel_s    = sync_bus[CODE_W-1:0];

  glc_edge #(.CODE_W(CODE_W)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_s (strobe_s),
    .sel_s    (sel_s),
    .en       (mode == MODE_STROBE),
    .fall     (fall),
    .rise     (rise),
    .sel_chg  (sel_chg)
  );

  glc_timing_mon #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW_CYC   (LOW_CYC)
  ) u_mon (
    .clk      (clk),
    .rst      (rst),
    .strobe_s (strobe_s),
    .fall     (fall),
    .rise     (rise),
    .sel_chg  (sel_chg),
    .viol_clr (viol_clr),
    .viol     (viol)
  );

  glc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .sel_s (sel_s),
    .fall  (fall),
    .code  (gain_exp),
    .gain  (gain_val),
    .chg   (gain_chg)
  );

  assign setup_err = viol.setup;
  assign hold_err  = viol.hold;
  assign high_err  = viol.high;
  assign low_err   = viol.low;

endmodule

// File: rtl/gain_latch_ctrl_chk.sv
module gain_latch_ctrl_chk #(
  parameter int CODE_W = 2,
  localparam int GAIN_W = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_mode,
  input logic              viol_clr,
  input logic [CODE_W-1:0] sel_s,
  input logic              fall,
  input logic [CODE_W-1:0] gain_exp,
  input logic [GAIN_W-1:0] gain_val,
  input logic              gain_chg,
  input logic              setup_err,
  input logic              hold_err,
  input logic              high_err,
  input logic              low_err
);

  a_r1_onehot_match: assert property (@(posedge clk) disable iff (rst)
    ($countones(gain_val) == 1) && gain_val[gain_exp]);

  a_r3_follow_bus: assert property (@(posedge clk) disable iff (rst)
    !latch_mode |=> (gain_exp == $past(sel_s)));

  a_r4_load_on_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> (gain_exp == $past(sel_s)));

  a_r5_keep_code: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && !fall) |=> $stable(gain_exp));

  a_r7_chg_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gain_chg == (gain_exp != $past(gain_exp))));

  a_r12_sticky_setup: assert property (@(posedge clk) disable iff (rst)
    (setup_err && !viol_clr) |=> setup_err);

  a_r12_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (hold_err && !viol_clr) |=> hold_err);

  a_r12_sticky_high: assert property (@(posedge clk) disable iff (rst)
    (high_err && !viol_clr) |=> high_err);

  a_r12_sticky_low: assert property (@(posedge clk) disable iff (rst)
    (low_err && !viol_clr) |=> low_err);

endmodule

bind gain_latch_ctrl gain_latch_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .latch_mode (latch_mode),
  .viol_clr   (viol_clr),
  .sel_s      (sel_s),
  .fall       (fall),
  .gain_exp   (gain_exp),
  .gain_val   (gain_val),
  .gain_chg   (gain_chg),
  .setup_err  (setup_err),
  .hold_err   (hold_err),
  .high_err   (high_err),
  .low_err    (low_err)
);

// File: tb/gain_latch_ctrl_test.sv
`timescale 1ns/1ps
module gain_latch_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_strobe = 1'b0;
  logic [1:0] gain_sel = 2'b11;
  logic       latch_mode = 1'b1;
  logic       viol_clr = 1'b0;
  logic [1:0] gain_exp;
  logic [3:0] gain_val;
  logic       gain_chg, setup_err, hold_err, high_err, low_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gain_latch_ctrl uut (
    .clk         (clk),
    .rst         (rst),
    .load_strobe (load_strobe),
    .gain_sel    (gain_sel),
    .latch_mode  (latch_mode),
    .viol_clr    (viol_clr),
    .gain_exp    (gain_exp),
    .gain_val    (gain_val),
    .gain_chg    (gain_chg),
    .setup_err   (setup_err),
    .hold_err    (hold_err),
    .high_err    (high_err),
    .low_err     (low_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_code(input string tag, input int code, input int chg);
    chk({tag, " exp"}, int'(gain_exp), code);
    chk({tag, " val"}, int'(gain_val), 1 << code);
    chk({tag, " chg"}, int'(gain_chg), chg);
  endtask

  task automatic chk_flags(input string tag, input int su, input int hd,
                           input int hi, input int lo);
    chk({tag, " setup_err"}, int'(setup_err), su);
    chk({tag, " hold_err"},  int'(hold_err),  hd);
    chk({tag, " high_err"},  int'(high_err),  hi);
    chk({tag, " low_err"},   int'(low_err),   lo);
  endtask

  task automatic clear_flags();
    viol_clr = 1'b1;
    tick(1);
    viol_clr = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    tick(4);
    chk_code("R2 in reset", 0, 0);
    chk_flags("R2 in reset", 0, 0, 0, 0);
    rst = 1'b0;
    tick(6);
    chk_code("R2 strobe mode after reset, bus=11", 0, 0);
    chk_flags("R2 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_follow();
    latch_mode = 1'b0;
    tick(1);
    chk_code("R6 follow mode next edge", 3, 1);
    tick(3);
    for (int i = 0; i < 4; i++) begin
      gain_sel = 2'(i);
      tick(2);
      chk("R3 latency old value", int'(gain_exp), (i == 0) ? 3 : i - 1);
      chk("R7 no pulse early", int'(gain_chg), 0);
      tick(1);
      chk_code("R1 R3 R7 follow new code", i, 1);
      tick(1);
      chk("R7 pulse one cycle", int'(gain_chg), 0);
    end
    chk_flags("R12 follow mode quiet", 0, 0, 0, 0);
  endtask

  task automatic t_strobe_load();
    latch_mode = 1'b1;
    gain_sel   = 2'b01;
    tick(5);
    chk_code("R6 entering strobe mode keeps code", 3, 0);
    load_strobe = 1'b1;
    tick(4);
    load_strobe = 1'b0;
    tick(2);
    chk("R4 latency old value", int'(gain_exp), 3);
    tick(1);
    chk_code("R4 load on fall", 1, 1);
    tick(1);
    chk("R7 pulse ends", int'(gain_chg), 0);
    tick(4);
    gain_sel = 2'b10;
    tick(5);
    chk_code("R5 strobe low, bus change", 1, 0);
    load_strobe = 1'b1;
    tick(5);
    chk_code("R5 strobe rise", 1, 0);
    tick(5);
    chk_code("R5 strobe high", 1, 0);
    chk_flags("R4 clean load", 0, 0, 0, 0);
  endtask

  task automatic t_setup();
    gain_sel = 2'b11;
    tick(1);
    load_strobe = 1'b0;
    tick(3);
    chk_code("R8 short setup still loads", 3, 1);
    chk_flags("R8 short setup", 1, 0, 0, 0);
    viol_clr = 1'b1;
    tick(1);
    viol_clr = 1'b0;
    chk("R12 clear", int'(setup_err), 0);
  endtask

  task automatic t_hold();
    tick(4);
    load_strobe = 1'b1;
    tick(4);
    gain_sel = 2'b00;
    tick(2);
    load_strobe = 1'b0;
    tick(1);
    gain_sel = 2'b10;
    tick(3);
    chk_code("R9 keeps loaded code", 0, 0);
    chk_flags("R8 setup boundary, R9 early change", 0, 1, 0, 0);
    clear_flags();
    tick(4);
    load_strobe = 1'b1;
    tick(4);
    load_strobe = 1'b0;
    tick(2);
    gain_sel = 2'b01;
    tick(3);
    chk_code("R9 hold boundary load", 2, 0);
    chk_flags("R9 hold boundary", 0, 0, 0, 0);
  endtask

  task automatic t_width();
    clear_flags();
    tick(4);
    load_strobe = 1'b1;
    tick(2);
    load_strobe = 1'b0;
    tick(3);
    chk_flags("R10 short high", 0, 0, 1, 0);
    load_strobe = 1'b1;
    tick(4);
    viol_clr = 1'b1;
    tick(1);
    viol_clr = 1'b0;
    load_strobe = 1'b0;
    tick(2);
    load_strobe = 1'b1;
    tick(3);
    chk_flags("R11 short low", 0, 0, 0, 1);
    load_strobe = 1'b0;
    tick(3);
    chk_flags("R10 high boundary, R12 low sticky", 0, 0, 0, 1);
  endtask

  task automatic t_sticky();
    tick(4);
    clear_flags();
    latch_mode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      load_strobe = ~load_strobe;
      tick(1);
    end
    load_strobe = 1'b0;
    tick(4);
    chk_flags("R12 follow mode ignores fast strobe", 0, 0, 0, 0);
    latch_mode = 1'b1;
    tick(4);
    load_strobe = 1'b1;
    tick(1);
    load_strobe = 1'b0;
    tick(2);
    viol_clr = 1'b1;
    tick(1);
    viol_clr = 1'b0;
    chk("R12 set beats clear", int'(high_err), 1);
    tick(2);
    chk("R12 stays set", int'(high_err), 1);
  endtask

  initial begin
    t_reset();
    t_follow();
    t_strobe_load();
    t_setup();
    t_hold();
    t_width();
    t_sticky();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule